// File: doc/BRIEF.md
# Time-Limited Prefetch Read Cache Controller

This block manages the prefetch buffer on the secondary side of a bus bridge. An upstream initiator opens a read at a start address for a given number of words. The block fetches consecutive words from the downstream target into a small ring buffer and hands them back in address order. The read ends when the last word has been returned.

When the caching mode is off, whatever was fetched beyond the read is thrown away as soon as the read ends. When the mode is on, the data is kept and fetching carries on until a programmed amount is buffered. If the initiator comes back for the next word in the stream, the buffered words are returned at once. If it does not come back within a fixed idle window, the buffer is dropped. The mode suits targets that give only a short burst (on the order of 128 to 512 bytes) before disconnecting. It is safe only when nothing else can modify the buffered region between two reads.

Top module: `sec_prefetch_cache`

## Requirements
- R1: Out of reset, `ret_valid_o`, `req_done_o` and `fetch_en_o` are all low.
- R2: Caching mode is on only while `en_lo_i`, `en_hi_i` and `pci_mode_i` are all 1 (`pci_mode_i`=1 means conventional mode, 0 means the split-transaction mode). When the mode is off and no read is open, any held data is dropped at the next edge, `fetch_en_o` is low from the following cycle, and a later read at the stream's next address is treated as a miss.
- R3: With the mode off, the edge that returns a read's last word also drops the buffer; `fetch_en_o` is low in the next cycle.
- R4: With the mode on, fetching goes on after a read ends until the buffer holds (`limit_i`+1)*DEPTH/8 words (4 to 32 words at the defaults). The same cap also holds while a read is open.
- R5: A hit is a read started while the mode is on and the buffer is valid, at the address equal to the next unreturned buffered address. Its first word appears on `ret_valid_o`/`ret_data_o` in the cycle after the start edge and is the word fetched earlier, even if the target has changed it since.
- R6: Any other read is a miss. It drops the buffer and fetches from `req_addr_i`. When the target supplies at once, the first word appears two cycles after the start edge. Word i of a read is the target's word at `req_addr_i`+i (16-bit address wrap).
- R7: The idle window restarts at every returned word. A read whose start is sampled up to 64 edges after the edge that returned the last word can hit. A read started later misses.
- R8: A read returns exactly `req_len_i` words (1 to 63). `req_done_o` is high together with the last word, and no word follows it. A start pulse while a read is open is ignored.
- R9: A fill word is taken on an edge where both `fetch_en_o` and `fill_valid_i` are high. `fill_data_i` must be the target's word at `fetch_addr_o`, which then steps by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Secondary-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_lo_i | input | 1 | First enable bit of the caching mode |
| en_hi_i | input | 1 | Second enable bit of the caching mode |
| pci_mode_i | input | 1 | 1 = conventional bus mode, 0 = split-transaction mode |
| limit_i | input | LW (3) | Prefetch amount code |
| req_start_i | input | 1 | One-cycle pulse opening a read |
| req_addr_i | input | AW (16) | Start word address of the read |
| req_len_i | input | LENW (6) | Words requested, 1 to 63 |
| req_done_o | output | 1 | High with the last returned word of a read |
| fetch_en_o | output | 1 | Block wants the word at fetch_addr_o |
| fetch_addr_o | output | AW (16) | Address of the next word to fetch |
| fill_valid_i | input | 1 | Target offers fill_data_i this cycle |
| fill_data_i | input | DW (16) | Target word for fetch_addr_o |
| ret_valid_o | output | 1 | A word is returned to the initiator this cycle |
| ret_data_o | output | DW (16) | Returned word |

## Verification
A hit returns its first word in the cycle after the start edge, and a miss returns it two cycles after. The bench records the sample index of every returned word relative to the start edge and checks it. Drop behaviour is due one edge after its cause: a read's last word, or the mode going off while no read is open. The bench samples `fetch_en_o` in the cycle that follows. For the idle window, the bench starts the next read exactly d edges after the last return, for d of 1, 63, 64, 65 and 100. The target's data carries a generation tag that changes before each read, so a hit and a miss can be told apart from the returned words alone.

// File: rtl/spc_pkg.sv
`timescale 1ns/1ps
package spc_pkg;
  typedef enum logic [1:0] {
    REQ_NONE,
    REQ_HIT,
    REQ_MISS
  } req_kind_e;
endpackage

// File: rtl/spc_buf.sv
`timescale 1ns/1ps
module spc_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     push_i,
  input  logic [DW-1:0]            push_data_i,
  input  logic                     pop_i,
  output logic [DW-1:0]            head_o,
  output logic [$clog2(DEPTH):0]   cnt_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + PW'(1);
      if (pop_i)  rd_q <= rd_q + PW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o = mem_q[rd_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/spc_idle_tmr.sv
`timescale 1ns/1ps
module spc_idle_tmr #(
  parameter int IDLE_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int TW = $clog2(IDLE_CYC + 1);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        tmr_q <= '0;
    else if (load_i)                    tmr_q <= TW'(IDLE_CYC);
    else if (run_i && tmr_q != '0)      tmr_q <= tmr_q - TW'(1);
  end

  assign expire_o = run_i && (tmr_q == TW'(1));
endmodule

// File: rtl/sec_prefetch_cache.sv
`timescale 1ns/1ps
module sec_prefetch_cache #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int DEPTH    = 32,
  parameter int LW       = 3,
  parameter int LENW     = 6,
  parameter int IDLE_CYC = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_lo_i,
  input  logic            en_hi_i,
  input  logic            pci_mode_i,
  input  logic [LW-1:0]   limit_i,
  input  logic            req_start_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [LENW-1:0] req_len_i,
  output logic            req_done_o,
  output logic            fetch_en_o,
  output logic [AW-1:0]   fetch_addr_o,
  input  logic            fill_valid_i,
  input  logic [DW-1:0]   fill_data_i,
  output logic            ret_valid_o,
  output logic [DW-1:0]   ret_data_o
);
  import spc_pkg::*;

  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = PW + 1;
  localparam int STEP = DEPTH >> LW;

  logic            feat, start, pop, last, fill, clr, expire, tmr_run;
  logic            valid_q, act_q;
  logic [LENW-1:0] rem_q;
  logic [AW-1:0]   head_q, fadr_q;
  logic [CW-1:0]   cnt, lim_w;
  req_kind_e       kind;

  always_comb begin
    feat  = en_lo_i & en_hi_i & pci_mode_i;
    lim_w = CW'(limit_i) * CW'(STEP) + CW'(STEP);
    start = req_start_i & ~act_q;
    kind  = REQ_NONE;
    if (start) kind = (valid_q && feat && req_addr_i == head_q) ? REQ_HIT : REQ_MISS;
    pop        = act_q && cnt != '0;
    last       = pop && rem_q == LENW'(1);
    fetch_en_o = valid_q && (act_q || feat) && cnt < lim_w;
    fill       = fetch_en_o && fill_valid_i;
    tmr_run    = valid_q && !act_q && feat;
    // miss, non-cached completion, or idle drop (mode off / window over)
    clr = (kind == REQ_MISS) || (last && !feat) ||
          (!act_q && !start && valid_q && (!feat || expire));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      act_q   <= 1'b0;
      rem_q   <= '0;
      head_q  <= '0;
      fadr_q  <= '0;
    end else if (kind == REQ_MISS) begin
      valid_q <= 1'b1;
      act_q   <= 1'b1;
      rem_q   <= req_len_i;
      head_q  <= req_addr_i;
      fadr_q  <= req_addr_i;
    end else begin
      if (kind == REQ_HIT) begin
        act_q <= 1'b1;
        rem_q <= req_len_i;
      end
      if (clr) valid_q <= 1'b0;
      if (pop) begin
        head_q <= head_q + AW'(1);
        rem_q  <= rem_q - LENW'(1);
        if (last) act_q <= 1'b0;
      end
      if (fill && !clr) fadr_q <= fadr_q + AW'(1);
    end
  end

  spc_buf #(.DW(DW), .DEPTH(DEPTH)) i_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .push_i      (fill),
    .push_data_i (fill_data_i),
    .pop_i       (pop),
    .head_o      (ret_data_o),
    .cnt_o       (cnt)
  );

  spc_idle_tmr #(.IDLE_CYC(IDLE_CYC)) i_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (pop),
    .run_i    (tmr_run),
    .expire_o (expire)
  );

  assign ret_valid_o  = pop;
  assign req_done_o   = last;
  assign fetch_addr_o = fadr_q;
endmodule

// File: rtl/spc_checker.sv
`timescale 1ns/1ps
module spc_checker #(
  parameter int IDLE_CYC = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_lo_i,
  input logic en_hi_i,
  input logic pci_mode_i,
  input logic req_start_i,
  input logic req_done_o,
  input logic fetch_en_o,
  input logic ret_valid_o,
  input logic act_i,
  input logic valid_i
);
  localparam int IW = $clog2(IDLE_CYC + 1);

  logic          feat;
  logic [IW-1:0] idle_q;

  assign feat = en_lo_i & en_hi_i & pci_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       idle_q <= IW'(IDLE_CYC);
    else if (ret_valid_o)              idle_q <= '0;
    else if (idle_q != IW'(IDLE_CYC))  idle_q <= idle_q + IW'(1);
  end

  p_done_has_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |-> ret_valid_o);

  p_quiet_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |=> !ret_valid_o);

  p_drop_on_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_done_o && !feat) |=> !fetch_en_o);

  p_idle_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_i && !feat && !req_start_i) |=> !fetch_en_o);

  p_window_over_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_i && idle_q == IW'(IDLE_CYC)) |-> !valid_i);
endmodule

bind sec_prefetch_cache spc_checker #(.IDLE_CYC(IDLE_CYC)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_lo_i     (en_lo_i),
  .en_hi_i     (en_hi_i),
  .pci_mode_i  (pci_mode_i),
  .req_start_i (req_start_i),
  .req_done_o  (req_done_o),
  .fetch_en_o  (fetch_en_o),
  .ret_valid_o (ret_valid_o),
  .act_i       (act_q),
  .valid_i     (valid_q)
);

// File: tb/test_sec_prefetch_cache.sv
`timescale 1ns/1ps
module test_sec_prefetch_cache;
  localparam int STEP = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_lo_i = 1'b0, en_hi_i = 1'b0, pci_mode_i = 1'b1;
  logic [2:0]  limit_i = '0;
  logic        req_start_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [5:0]  req_len_i = '0;
  logic        req_done_o, fetch_en_o, ret_valid_o;
  logic [15:0] fetch_addr_o, ret_data_o, fill_data_i;
  logic        fill_valid_i = 1'b1;
  logic [3:0]  gen = '0;
  bit          stall = 1'b0;

  int checks = 0, errors = 0;
  int fills, rets, dones, k;
  logic [15:0] got [64];
  int          got_k [64];

  always #2.5 clk = ~clk;

  assign fill_data_i = fetch_addr_o ^ {gen, 12'h000};

  sec_prefetch_cache i_sec_prefetch_cache (
    .clk_i(clk), .rst_ni(rst_ni), .en_lo_i(en_lo_i), .en_hi_i(en_hi_i),
    .pci_mode_i(pci_mode_i), .limit_i(limit_i), .req_start_i(req_start_i),
    .req_addr_i(req_addr_i), .req_len_i(req_len_i), .req_done_o(req_done_o),
    .fetch_en_o(fetch_en_o), .fetch_addr_o(fetch_addr_o),
    .fill_valid_i(fill_valid_i), .fill_data_i(fill_data_i),
    .ret_valid_o(ret_valid_o), .ret_data_o(ret_data_o));

  function automatic logic [15:0] word(input logic [15:0] a, input logic [3:0] g);
    return a ^ {g, 12'h000};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // sample before the edge, then step past it
  task automatic cycle();
    @(negedge clk);
    if (fetch_en_o && fill_valid_i) fills++;
    if (ret_valid_o) begin
      if (rets < 64) begin got[rets] = ret_data_o; got_k[rets] = k; end
      rets++;
    end
    if (req_done_o) dones++;
    k++;
    @(posedge clk); #1;
    fill_valid_i = stall ? ~fill_valid_i : 1'b1;
  endtask

  task automatic run_req(input logic [15:0] a, input int len, input bit poke);
    req_start_i = 1'b1; req_addr_i = a; req_len_i = 6'(len);
    rets = 0; dones = 0; k = 0;
    cycle();
    req_start_i = 1'b0;
    fills = 0;
    while (dones == 0 && k < 400) begin
      if (poke && k == 3) begin req_start_i = 1'b1; req_addr_i = a ^ 16'h0400; end
      else req_start_i = 1'b0;
      cycle();
    end
    req_start_i = 1'b0;
  endtask

  task automatic check_data(input logic [15:0] a, input int len, input int n_old,
                            input logic [3:0] g_old, input logic [3:0] g_new,
                            input string tag);
    chk(rets == len, {tag, " R8 word count"}, rets, len);
    chk(dones == 1, {tag, " R8 done count"}, dones, 1);
    for (int i = 0; i < len && i < 64; i++) begin
      logic [15:0] e;
      e = word(a + 16'(i), (i < n_old) ? g_old : g_new);
      chk(got[i] == e, {tag, " data"}, got[i], e);
    end
  endtask

  task automatic peek_fetch(output bit v);
    @(negedge clk);
    v = fetch_en_o;
    @(posedge clk); #1;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit v;
    logic [15:0] base;
    logic [3:0] g0;
    int n_old, lim;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(ret_valid_o == 0, "R1 reset ret_valid", ret_valid_o, 0);
    chk(req_done_o == 0,  "R1 reset done", req_done_o, 0);
    chk(fetch_en_o == 0,  "R1 reset fetch_en", fetch_en_o, 0);
    @(posedge clk); #1;

    // mode off (one enable low): miss path, drop at completion
    en_lo_i = 1'b0; en_hi_i = 1'b1; pci_mode_i = 1'b1;
    for (int ai = 0; ai < 3; ai++) begin
      for (int li = 0; li < 3; li++) begin
        for (int s = 0; s < 2; s++) begin
          int len;
          logic [15:0] a;
          a = (ai == 0) ? 16'h0010 : (ai == 1) ? 16'h0200 : 16'hFFFC;
          len = (li == 0) ? 1 : (li == 1) ? 5 : 17;
          stall = (s == 1);
          gen = gen + 4'd1;
          run_req(a, len, (li == 2));
          check_data(a, len, 0, gen, gen, "R6 R9 off-mode read");
          if (!stall) chk(got_k[0] == 2, "R6 miss latency", got_k[0], 2);
          peek_fetch(v);
          chk(v == 0, "R3 fetch stops after done", v, 0);
        end
      end
    end
    stall = 1'b0;

    // mode on: limit sweep, then hit on the continuation
    en_lo_i = 1'b1; en_hi_i = 1'b1; pci_mode_i = 1'b1;
    for (int code = 0; code < 8; code++) begin
      limit_i = 3'(code);
      lim = (code + 1) * STEP;
      base = 16'(code * 16'h0100 + 16'h0040);
      gen = gen + 4'd1; g0 = gen;
      run_req(base, 3, 1'b0);
      check_data(base, 3, 0, g0, g0, "R6 first read");
      repeat (50) cycle();
      chk(fills - 3 == lim, "R4 buffered words", fills - 3, lim);
      chk(fetch_en_o == 0, "R4 fetch idle at cap", fetch_en_o, 0);
      gen = gen + 4'd1;
      run_req(base + 16'd3, lim + 3, 1'b0);
      check_data(base + 16'd3, lim + 3, lim, g0, gen, "R5 hit read");
      chk(got_k[0] == 1, "R5 hit latency", got_k[0], 1);
    end

    // mismatched address misses
    limit_i = 3'd1;
    gen = gen + 4'd1;
    run_req(16'h3000, 4, 1'b0);
    repeat (10) cycle();
    gen = gen + 4'd1;
    run_req(16'h3005, 4, 1'b0);
    check_data(16'h3005, 4, 0, gen, gen, "R6 skip-ahead miss");
    chk(got_k[0] == 2, "R6 skip-ahead latency", got_k[0], 2);
    repeat (10) cycle();
    gen = gen + 4'd1;
    run_req(16'h3008, 4, 1'b0);
    check_data(16'h3008, 4, 0, gen, gen, "R6 back-step miss");
    chk(got_k[0] == 2, "R6 back-step latency", got_k[0], 2);

    // idle window boundary
    for (int di = 0; di < 5; di++) begin
      int d;
      bit hit;
      d = (di == 0) ? 1 : (di == 1) ? 63 : (di == 2) ? 64 : (di == 3) ? 65 : 100;
      hit = (d <= 64);
      base = 16'(16'h5000 + di * 16'h0100);
      gen = gen + 4'd1; g0 = gen;
      run_req(base, 4, 1'b0);
      for (int i = 1; i < d; i++) cycle();
      n_old = hit ? fills - 4 : 0;
      gen = gen + 4'd1;
      run_req(base + 16'd4, 4, 1'b0);
      check_data(base + 16'd4, 4, n_old, g0, gen, "R7 window read");
      chk(got_k[0] == (hit ? 1 : 2), "R7 window hit/miss latency", got_k[0], hit ? 1 : 2);
    end

    // dropping any enable input while idle discards the buffer
    for (int vb = 0; vb < 3; vb++) begin
      base = 16'(16'h7000 + vb * 16'h0100);
      gen = gen + 4'd1;
      run_req(base, 4, 1'b0);
      repeat (20) cycle();
      if (vb == 0) en_lo_i = 1'b0; else if (vb == 1) en_hi_i = 1'b0; else pci_mode_i = 1'b0;
      cycle();
      en_lo_i = 1'b1; en_hi_i = 1'b1; pci_mode_i = 1'b1;
      peek_fetch(v);
      chk(v == 0, "R2 fetch stops on mode off", v, 0);
      gen = gen + 4'd1;
      run_req(base + 16'd4, 4, 1'b0);
      check_data(base + 16'd4, 4, 0, gen, gen, "R2 read after mode off");
      chk(got_k[0] == 2, "R2 miss after mode off", got_k[0], 2);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule